// File: doc/BRIEF.md
# Bus Target Selection Responder

This block sits on the target side of an 8-bit parallel peripheral bus and decides when an initiator is selecting it. Each clock it samples the bus control lines (busy, select, input/output direction, reset) together with the eight data lines and their parity line. A selection counts only when the qualifying condition holds without a break for a settle interval of `SETTLE_CYC` clocks. The qualifying condition is: select asserted, the target's own ID bit set on the data bus, and busy and input/output both deasserted.

Once the settle interval has run out, the block decodes the initiator ID from the one other data bit that is set. It also checks odd parity when that check is enabled and no arbitration is in progress. If both pass, it pulses `selected` and raises its busy drive enable in that same clock. If either fails, it raises a one-clock error pulse instead and stays off the bus. The busy drive is then held until the local logic gives a release, or until a bus reset arrives while select is low. No new decision is made until the qualifying condition has dropped for at least one clock.

All pins are plain control and status levels. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sel_responder`

## Requirements
- R1: `selected` pulses high for exactly one clock, in the clock after the `SETTLE_CYC`-th consecutive clock edge at which the qualifying condition held. The qualifying condition is `bus_sel`=1, `bus_db[own_id]`=1, `bus_bsy`=0 and `bus_io`=0. Before that count is reached, `selected` stays 0.
- R2: `bsy_drive` rises in the same clock as the `selected` pulse, and it rises at no other time.
- R3: If the qualifying condition is absent at any edge before the count completes, the count restarts from zero.
- R4: While `bus_io`=1, the block never makes a selection decision.
- R5: `init_id` is the binary index of the single data bit other than `own_id` that is set. It is captured on the `selected` pulse and held while `bsy_drive` is 1.
- R6: If zero or more than one data bit other than `own_id` is set when the count completes, `id_err` pulses for one clock and the block does not respond.
- R7: Parity is odd over `bus_db` and `bus_dbp`, so the XOR of all nine bits must be 1. With `par_en`=1 and `arb_active`=0, even parity at decision time pulses `par_err` for one clock and the block does not respond. An ID error takes precedence over a parity error.
- R8: With `par_en`=0 or `arb_active`=1, parity has no effect on the decision.
- R9: `bsy_drive` stays 1 until `release_i`=1, or until `bus_rst`=1 while `bus_sel`=0. `bus_rst` with `bus_sel`=1 does not release it.
- R10: After any decision (response or error), no further decision is made until the qualifying condition has been absent at one edge.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_id | input | 3 | This target's ID, 0 to 7 |
| par_en | input | 1 | Enable the parity check |
| arb_active | input | 1 | Arbitration in progress; parity is not valid |
| bus_bsy | input | 1 | Sampled busy line, 1 = asserted |
| bus_sel | input | 1 | Sampled select line, 1 = asserted |
| bus_io | input | 1 | Sampled input/output line, 1 = asserted |
| bus_rst | input | 1 | Sampled bus reset line |
| bus_db | input | 8 | Sampled data lines |
| bus_dbp | input | 1 | Sampled data parity line |
| release_i | input | 1 | Local request to drop busy |
| bsy_drive | output | 1 | Busy drive enable |
| selected | output | 1 | One-clock selection pulse |
| init_id | output | 3 | Decoded initiator ID |
| id_err | output | 1 | One-clock ID error pulse |
| par_err | output | 1 | One-clock parity error pulse |

## Verification
The bench builds the block with `SETTLE_CYC`=3, which keeps each settle window short. That makes it cheap to sweep all eight own IDs against all 256 data-bus values, covering every ID-decode outcome: not addressed, one valid initiator, no initiator bit, and several initiator bits. At every point it checks the clock one edge before the count ends and the clock at which the decision appears. Directed cases then cover a qualifying condition broken mid-count, a raised input/output line, bad parity with the check on, off and masked by arbitration, both release paths, and a condition held on after an error.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } sel_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic qual,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = qual && !clr && (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !qual) cnt_q <= '0;
    else if (!done)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/id_decode.sv
module id_decode #(
  parameter int DB_W = 8,
  localparam int ID_W = $clog2(DB_W)
) (
  input  logic [DB_W-1:0] db,
  input  logic [ID_W-1:0] own_id,
  output logic            single,
  output logic [ID_W-1:0] id
);
  localparam int PW = $clog2(DB_W + 1);

  logic [DB_W-1:0] other;
  logic [PW-1:0]   ones;

  always_comb begin
    other = db & ~(DB_W'(1) << own_id);
    ones  = '0;
    id    = '0;
    for (int i = 0; i < DB_W; i++) begin
      if (other[i]) begin
        ones = ones + 1'b1;
        id   = ID_W'(i);
      end
    end
    single = (ones == PW'(1));
  end
endmodule

// File: rtl/parity_chk.sv
module parity_chk #(
  parameter int DB_W = 8
) (
  input  logic [DB_W-1:0] db,
  input  logic            dbp,
  input  logic            en,
  input  logic            arb,
  output logic            bad
);
  assign bad = en && !arb && !(^{db, dbp});
endmodule

// File: rtl/sel_responder.sv
module sel_responder #(
  parameter int SETTLE_CYC = 8,
  parameter int DB_W       = 8,
  localparam int ID_W      = $clog2(DB_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] own_id,
  input  logic            par_en,
  input  logic            arb_active,
  input  logic            bus_bsy,
  input  logic            bus_sel,
  input  logic            bus_io,
  input  logic            bus_rst,
  input  logic [DB_W-1:0] bus_db,
  input  logic            bus_dbp,
  input  logic            release_i,
  output logic            bsy_drive,
  output logic            selected,
  output logic [ID_W-1:0] init_id,
  output logic            id_err,
  output logic            par_err
);
  import sel_pkg::*;

  sel_state_e      st_q;
  logic            qual, done, single, pbad, drop;
  logic [ID_W-1:0] dec_id;

  assign qual = bus_sel && !bus_bsy && !bus_io && bus_db[own_id];
  assign drop = release_i || (bus_rst && !bus_sel);

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(st_q != ST_ARM), .qual(qual), .done(done)
  );

  id_decode #(.DB_W(DB_W)) dec_i (
    .db(bus_db), .own_id(own_id), .single(single), .id(dec_id)
  );

  parity_chk #(.DB_W(DB_W)) par_i (
    .db(bus_db), .dbp(bus_dbp), .en(par_en), .arb(arb_active), .bad(pbad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_ARM;
      bsy_drive <= 1'b0;
      selected  <= 1'b0;
      init_id   <= '0;
      id_err    <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      selected <= 1'b0;
      id_err   <= 1'b0;
      par_err  <= 1'b0;
      unique case (st_q)
        ST_ARM: if (done) begin
          if (!single)   begin id_err  <= 1'b1; st_q <= ST_WAIT; end
          else if (pbad) begin par_err <= 1'b1; st_q <= ST_WAIT; end
          else begin
            selected  <= 1'b1;
            bsy_drive <= 1'b1;
            init_id   <= dec_id;
            st_q      <= ST_HOLD;
          end
        end
        ST_HOLD: if (drop) begin
          bsy_drive <= 1'b0;
          st_q      <= ST_WAIT;
        end
        ST_WAIT: if (!qual) st_q <= ST_ARM;
        default: st_q <= ST_ARM;
      endcase
    end
  end
endmodule

// File: rtl/sel_responder_chk.sv
module sel_responder_chk #(
  parameter int SETTLE_CYC = 8,
  parameter int DB_W       = 8,
  localparam int ID_W      = $clog2(DB_W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ID_W-1:0] own_id,
  input logic            bus_bsy,
  input logic            bus_sel,
  input logic            bus_io,
  input logic            bus_rst,
  input logic [DB_W-1:0] bus_db,
  input logic            release_i,
  input logic            bsy_drive,
  input logic            selected,
  input logic [ID_W-1:0] init_id,
  input logic            id_err,
  input logic            par_err
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic          q_now;
  logic [CW-1:0] run_q;

  assign q_now = bus_sel && !bus_bsy && !bus_io && bus_db[own_id];

  always_ff @(posedge clk) begin
    if (!rst_n || !q_now)               run_q <= '0;
    else if (run_q != CW'(SETTLE_CYC))  run_q <= run_q + 1'b1;
  end

  assert_settle_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> run_q == CW'(SETTLE_CYC));
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    selected |=> !selected);
  assert_bsy_with_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> bsy_drive);
  assert_bsy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_drive) |-> selected);
  assert_no_resel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_io |=> !selected && !id_err && !par_err);
  assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_drive && !selected |-> $stable(init_id));
  assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({selected, id_err, par_err}) <= 1);
  assert_bsy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_drive && !release_i && !(bus_rst && !bus_sel) |=> bsy_drive);
endmodule

bind sel_responder sel_responder_chk #(.SETTLE_CYC(SETTLE_CYC), .DB_W(DB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .own_id(own_id), .bus_bsy(bus_bsy), .bus_sel(bus_sel),
  .bus_io(bus_io), .bus_rst(bus_rst), .bus_db(bus_db), .release_i(release_i),
  .bsy_drive(bsy_drive), .selected(selected), .init_id(init_id),
  .id_err(id_err), .par_err(par_err)
);

// File: tb/sel_responder_tb_top.sv
module sel_responder_tb_top;
  localparam int SC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] own_id = '0;
  logic       par_en = 1'b1, arb_active = 1'b0;
  logic       bus_bsy = 1'b0, bus_sel = 1'b0, bus_io = 1'b0, bus_rst = 1'b0;
  logic [7:0] bus_db = '0;
  logic       bus_dbp = 1'b0, release_i = 1'b0;
  logic       bsy_drive, selected, id_err, par_err;
  logic [2:0] init_id;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sel_responder #(.SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .par_en(par_en),
    .arb_active(arb_active), .bus_bsy(bus_bsy), .bus_sel(bus_sel),
    .bus_io(bus_io), .bus_rst(bus_rst), .bus_db(bus_db), .bus_dbp(bus_dbp),
    .release_i(release_i), .bsy_drive(bsy_drive), .selected(selected),
    .init_id(init_id), .id_err(id_err), .par_err(par_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic io, logic [7:0] d, logic pgood);
    bus_sel = s; bus_io = io; bus_db = d;
    bus_dbp = pgood ? ~^d : ^d;
  endtask

  task automatic cleanup();
    drive(1'b0, 1'b0, 8'h00, 1'b1);
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle_and_check(string req, int e_sel, int e_id_err, int e_par_err);
    repeat (SC) @(negedge clk);
    chk({req, " selected"}, selected, e_sel);
    chk({req, " bsy_drive"}, bsy_drive, e_sel);
    chk({req, " id_err"}, id_err, e_id_err);
    chk({req, " par_err"}, par_err, e_par_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 bsy_drive", bsy_drive, 0);
    chk("R11 selected", selected, 0);
    chk("R11 errs", id_err + par_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5 R6: sweep every own ID against every data value
    for (int o = 0; o < 8; o++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] oth;
        int pc, idx, hit, es, ee;
        own_id = 3'(o);
        oth = 8'(v) & ~(8'd1 << o);
        pc = 0; idx = 0;
        for (int b = 0; b < 8; b++) if (oth[b]) begin pc++; idx = b; end
        hit = (v >> o) & 1;
        es = (hit == 1 && pc == 1) ? 1 : 0;
        ee = (hit == 1 && pc != 1) ? 1 : 0;
        drive(1'b1, 1'b0, 8'(v), 1'b1);
        repeat (SC - 1) @(negedge clk);
        chk("R1 early", selected + id_err, 0);
        @(negedge clk);
        chk("R1 selected", selected, es);
        chk("R2 bsy_drive", bsy_drive, es);
        chk("R6 id_err", id_err, ee);
        if (es == 1) chk("R5 init_id", init_id, idx);
        cleanup();
        if (es == 1) chk("R9 release_i", bsy_drive, 0);
      end
    end

    own_id = 3'd2;
    // R3: break after SC-1 edges, then a full count must still be needed
    drive(1'b1, 1'b0, 8'h24, 1'b1);
    repeat (SC - 1) @(negedge clk);
    bus_bsy = 1'b1;
    @(negedge clk);
    bus_bsy = 1'b0;
    repeat (SC - 1) @(negedge clk);
    chk("R3 restarted", selected, 0);
    @(negedge clk);
    chk("R3 full count", selected, 1);
    chk("R5 init_id", init_id, 5);
    // R5 hold of init_id while data changes
    bus_db = 8'h0C; bus_dbp = ~^bus_db;
    repeat (4) @(negedge clk);
    chk("R5 init_id held", init_id, 5);
    // R9 bus_rst with select high keeps busy
    bus_rst = 1'b1;
    @(negedge clk);
    chk("R9 rst with sel", bsy_drive, 1);
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R9 rst no sel", bsy_drive, 0);
    bus_rst = 1'b0;
    cleanup();

    // R4: io asserted for a long time
    drive(1'b1, 1'b1, 8'h84, 1'b1);
    repeat (SC + 3) @(negedge clk);
    chk("R4 io no response", selected + bsy_drive + id_err + par_err, 0);
    cleanup();

    // R7: bad parity, check on
    par_en = 1'b1; arb_active = 1'b0;
    drive(1'b1, 1'b0, 8'h44, 1'b0);
    settle_and_check("R7", 0, 0, 1);
    cleanup();
    // R7: ID error beats parity error
    drive(1'b1, 1'b0, 8'hC4, 1'b0);
    settle_and_check("R7 precedence", 0, 1, 0);
    cleanup();
    // R8: check off
    par_en = 1'b0;
    drive(1'b1, 1'b0, 8'h44, 1'b0);
    settle_and_check("R8 par_en off", 1, 0, 0);
    cleanup();
    // R8: arbitration masks parity
    par_en = 1'b1; arb_active = 1'b1;
    drive(1'b1, 1'b0, 8'h44, 1'b0);
    settle_and_check("R8 arb", 1, 0, 0);
    arb_active = 1'b0;
    cleanup();

    // R10: condition held on after an ID error gives no second decision
    drive(1'b1, 1'b0, 8'h04, 1'b1);
    settle_and_check("R10 first", 0, 1, 0);
    repeat (3 * SC) @(negedge clk);
    chk("R10 no repeat", selected + id_err + par_err, 0);
    bus_db = 8'h06; bus_dbp = ~^bus_db;
    repeat (2 * SC) @(negedge clk);
    chk("R10 still blocked", selected + bsy_drive, 0);
    bus_sel = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1;
    settle_and_check("R10 rearmed", 1, 0, 0);
    cleanup();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule